// File: doc/BRIEF.md
# FM Tuner and Codec Bring-Up Sequencer

This block configures an FM receiver chip and checks an audio codec with no help from software. On reset release it runs a fixed series of I2C transactions through a byte-level I2C master. The master takes one command at a time: start, write byte, read byte with an acknowledge choice, or stop. For each command it reports whether the byte was acknowledged and returns the byte that was read.

The series has these steps:
- Power the tuner up and confirm that it reports ready.
- Fetch its 8-byte revision record.
- Tune to the frequency sampled from an input at reset release.
- Poll the tuner status until the tune-complete flag appears, then acknowledge the tune interrupt.
- Check the codec by writing a known pattern to its page register and reading it back.

The result appears as a held `done` or `error` flag. The revision bytes stay on an output vector. A `start` pulse from the done or error state runs the whole series again.

Top module: `radio_bringup_seq`

## Requirements
- R1: After reset release the block issues, with no other stimulus, the power-up transaction: START, 0x22, 0x01, 0xC0, 0x05, STOP. It then reads one status byte in the transaction START, 0x23, read, STOP. The tuner's write and read address bytes are 0x22 and 0x23.
- R2: Command encoding on `cmd_op` is 0 = START, 1 = WRITE, 2 = READ and 3 = STOP. While `cmd_valid` is high and `cmd_done` is low, `cmd_op`, `cmd_wdata` and `cmd_nack` hold steady. The command completes in the cycle in which `cmd_done` is high.
- R3: The revision step writes 0x10 in its own transaction (START, 0x22, 0x10, STOP). A second transaction reads 8 bytes from 0x23. Read byte k appears on `rev_data[8k+7:8k]`.
- R4: If bit 7 of the power-up status byte (ready flag) is clear, the block raises `error` and issues no further transaction.
- R5: The tune transaction is START, 0x22, 0x20, 0x00, freq[15:8], freq[7:0], STOP. The frequency is counted in 10 kHz units.
- R6: The poll step is START, 0x22, 0x14, STOP, followed by START, 0x23, two reads, STOP. It repeats until bit 0 of the first byte read (tune-complete flag) is set.
- R7: If `MAX_POLLS` poll reads in a row show the tune-complete flag clear, `error` rises after the last of them and no further transaction is issued.
- R8: After the tune completes, the interrupt is acknowledged with START, 0x22, 0x22, 0x01, STOP.
- R9: The codec check has three transactions: START, 0x30, 0x00, 0x42, STOP, then START, 0x30, 0x00, STOP, then START, 0x31, read, STOP. A byte equal to 0x42 raises `done`; any other value raises `error`.
- R10: In every read transaction, each byte except the last is read with ACK (`cmd_nack` = 0) and the last byte is read with NACK (`cmd_nack` = 1).
- R11: If an address or data byte is not acknowledged, the block issues STOP, raises `error` and starts no further transaction.
- R12: `done` and `error` are 0 in reset and never high together. Once raised, each holds with the bus idle until `start`. A `start` pulse clears both, samples `tune_freq` again and reruns the series from R1.
- R13: A `start` pulse or a change of `tune_freq` while the series is running has no effect on the bytes issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; `tune_freq` is sampled while it is high |
| start | input | 1 | Rerun request, taken only in the done or error state |
| tune_freq | input | 16 | Tune frequency in 10 kHz units |
| cmd_valid | output | 1 | A command is presented to the I2C master |
| cmd_op | output | 2 | Command: 0 START, 1 WRITE, 2 READ, 3 STOP |
| cmd_wdata | output | 8 | Byte to write (address or data) |
| cmd_nack | output | 1 | For READ: answer the byte with NACK |
| cmd_done | input | 1 | Master finished the presented command |
| rsp_ack | input | 1 | For WRITE: the target acknowledged the byte |
| rsp_rdata | input | 8 | For READ: byte received |
| done | output | 1 | Series completed successfully (held) |
| error | output | 1 | Series aborted (held) |
| rev_data | output | 64 | Revision bytes, byte k at bits [8k+7:8k] |

## Verification
Assertions check on every cycle that a presented command stays steady until it completes, that `done` and `error` never coincide, that the bus stays quiet while either is held, that a failed transaction leads to `error` one cycle later, and that the poll counter stays in range. The full byte stream cannot be checked by a property: its order, the acknowledge choice on each read, the frequency bytes, the number of poll rounds and the exact point at which an error truncates the series. The bench scenarios cover these. They compare the logged command stream with an expected stream computed for each frequency, poll count, injected NACK position and readback fault.

// File: rtl/radio_seq_pkg.sv
package radio_seq_pkg;

  localparam int MAX_WR  = 4;
  localparam int REV_LEN = 8;
  localparam int CNT_W   = 4;
  localparam int RIDX_W  = $clog2(REV_LEN);

  localparam logic [7:0] TUNER_WR = 8'h22;
  localparam logic [7:0] TUNER_RD = 8'h23;
  localparam logic [7:0] CODEC_WR = 8'h30;
  localparam logic [7:0] CODEC_RD = 8'h31;
  localparam logic [7:0] PAGE_PAT = 8'h42;
  localparam int READY_BIT = 7;
  localparam int TUNED_BIT = 0;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } i2c_op_e;

  typedef enum logic [3:0] {
    TX_PWR, TX_STAT, TX_REVCMD, TX_REVRD, TX_TUNE,
    TX_POLLCMD, TX_POLLRD, TX_INTACK, TX_PGWR, TX_PGPTR, TX_PGRD
  } txn_e;

  typedef struct packed {
    logic [7:0]             addr;
    logic [2:0]             wlen;
    logic [MAX_WR-1:0][7:0] wbytes;
    logic [CNT_W-1:0]       rlen;
  } txn_desc_t;

  function automatic txn_desc_t txn_desc(txn_e t, logic [15:0] freq);
    txn_desc_t d;
    d = '0;
    case (t)
      TX_PWR: begin
        d.addr = TUNER_WR; d.wlen = 3'd3;
        d.wbytes[0] = 8'h01; d.wbytes[1] = 8'hC0; d.wbytes[2] = 8'h05;
      end
      TX_STAT:    begin d.addr = TUNER_RD; d.rlen = 4'd1; end
      TX_REVCMD:  begin d.addr = TUNER_WR; d.wlen = 3'd1; d.wbytes[0] = 8'h10; end
      TX_REVRD:   begin d.addr = TUNER_RD; d.rlen = CNT_W'(REV_LEN); end
      TX_TUNE: begin
        d.addr = TUNER_WR; d.wlen = 3'd4;
        d.wbytes[0] = 8'h20; d.wbytes[1] = 8'h00;
        d.wbytes[2] = freq[15:8]; d.wbytes[3] = freq[7:0];
      end
      TX_POLLCMD: begin d.addr = TUNER_WR; d.wlen = 3'd1; d.wbytes[0] = 8'h14; end
      TX_POLLRD:  begin d.addr = TUNER_RD; d.rlen = 4'd2; end
      TX_INTACK: begin
        d.addr = TUNER_WR; d.wlen = 3'd2;
        d.wbytes[0] = 8'h22; d.wbytes[1] = 8'h01;
      end
      TX_PGWR: begin
        d.addr = CODEC_WR; d.wlen = 3'd2;
        d.wbytes[0] = 8'h00; d.wbytes[1] = PAGE_PAT;
      end
      TX_PGPTR:   begin d.addr = CODEC_WR; d.wlen = 3'd1; d.wbytes[0] = 8'h00; end
      TX_PGRD:    begin d.addr = CODEC_RD; d.rlen = 4'd1; end
      default: ;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/rbs_txn_engine.sv
module rbs_txn_engine
  import radio_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  txn_desc_t         desc,
  output logic              cmd_valid,
  output logic [1:0]        cmd_op,
  output logic [7:0]        cmd_wdata,
  output logic              cmd_nack,
  input  logic              cmd_done,
  input  logic              rsp_ack,
  input  logic [7:0]        rsp_rdata,
  output logic              rd_valid,
  output logic [RIDX_W-1:0] rd_idx,
  output logic [7:0]        rd_data,
  output logic              txn_done,
  output logic              txn_fail
);

  typedef enum logic [2:0] {E_IDLE, E_START, E_ADDR, E_WR, E_RD, E_STOP} eng_st_e;

  eng_st_e          st;
  txn_desc_t        d_q;
  logic [CNT_W-1:0] cnt;
  logic             last_wr, last_rd;

  assign last_wr = (cnt == CNT_W'(d_q.wlen) - CNT_W'(1));
  assign last_rd = (cnt == d_q.rlen - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= E_IDLE;
      d_q      <= '0;
      cnt      <= '0;
      txn_fail <= 1'b0;
      txn_done <= 1'b0;
      rd_valid <= 1'b0;
      rd_idx   <= '0;
      rd_data  <= '0;
    end else begin
      txn_done <= 1'b0;
      rd_valid <= 1'b0;
      case (st)
        E_IDLE: if (go) begin
          d_q      <= desc;
          txn_fail <= 1'b0;
          cnt      <= '0;
          st       <= E_START;
        end
        E_START: if (cmd_done) st <= E_ADDR;
        E_ADDR: if (cmd_done) begin
          cnt <= '0;
          if (!rsp_ack) begin
            txn_fail <= 1'b1;
            st       <= E_STOP;
          end else if (d_q.wlen != 3'd0) st <= E_WR;
          else if (d_q.rlen != '0)        st <= E_RD;
          else                            st <= E_STOP;
        end
        E_WR: if (cmd_done) begin
          if (!rsp_ack) begin
            txn_fail <= 1'b1;
            st       <= E_STOP;
          end else if (last_wr) begin
            cnt <= '0;
            st  <= (d_q.rlen != '0) ? E_RD : E_STOP;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        E_RD: if (cmd_done) begin
          rd_valid <= 1'b1;
          rd_idx   <= cnt[RIDX_W-1:0];
          rd_data  <= rsp_rdata;
          if (last_rd) st <= E_STOP;
          else         cnt <= cnt + CNT_W'(1);
        end
        E_STOP: if (cmd_done) begin
          txn_done <= 1'b1;
          st       <= E_IDLE;
        end
        default: st <= E_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd_valid = (st != E_IDLE);
    cmd_nack  = (st == E_RD) && last_rd;
    cmd_wdata = (st == E_ADDR) ? d_q.addr : d_q.wbytes[cnt[1:0]];
    case (st)
      E_ADDR, E_WR: cmd_op = OP_WRITE;
      E_RD:         cmd_op = OP_READ;
      E_STOP:       cmd_op = OP_STOP;
      default:      cmd_op = OP_START;
    endcase
  end

  // R2: a presented command holds until the master completes it
  a_r2_cmd_hold: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_done) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_wdata) && $stable(cmd_nack)));

  // R2: a new transaction is only requested while the bus is free
  a_r2_go_when_idle: assert property (@(posedge clk) disable iff (rst)
    go |-> !cmd_valid);

endmodule

// File: rtl/rbs_rev_file.sv
module rbs_rev_file #(
  parameter int N = 8,
  parameter int W = 8,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data,
  output logic [N*W-1:0] flat
);

  logic [W-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_out
    assign flat[g*W +: W] = mem[g];
  end

endmodule

// File: rtl/radio_bringup_seq.sv
module radio_bringup_seq
  import radio_seq_pkg::*;
#(
  parameter int MAX_POLLS = 64,
  localparam int POLL_W = $clog2(MAX_POLLS + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [15:0]          tune_freq,
  output logic                 cmd_valid,
  output logic [1:0]           cmd_op,
  output logic [7:0]           cmd_wdata,
  output logic                 cmd_nack,
  input  logic                 cmd_done,
  input  logic                 rsp_ack,
  input  logic [7:0]           rsp_rdata,
  output logic                 done,
  output logic                 error,
  output logic [8*REV_LEN-1:0] rev_data
);

  typedef enum logic [1:0] {S_LAUNCH, S_WAIT, S_DONE, S_ERR} seq_st_e;

  seq_st_e           st;
  txn_e              txn;
  logic [15:0]       freq_q;
  logic [POLL_W-1:0] poll_cnt;
  logic [7:0]        stat_q;
  logic              go;

  logic              rd_valid, txn_done, txn_fail;
  logic [RIDX_W-1:0] rd_idx;
  logic [7:0]        rd_data;
  txn_desc_t         desc;

  assign desc = txn_desc(txn, freq_q);

  rbs_txn_engine u_eng (
    .clk(clk), .rst(rst), .go(go), .desc(desc),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_wdata(cmd_wdata), .cmd_nack(cmd_nack),
    .cmd_done(cmd_done), .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata),
    .rd_valid(rd_valid), .rd_idx(rd_idx), .rd_data(rd_data),
    .txn_done(txn_done), .txn_fail(txn_fail)
  );

  rbs_rev_file #(.N(REV_LEN), .W(8)) u_rev (
    .clk(clk), .rst(rst),
    .wr_en(rd_valid && (txn == TX_REVRD)),
    .wr_idx(rd_idx), .wr_data(rd_data),
    .flat(rev_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_LAUNCH;
      txn      <= TX_PWR;
      freq_q   <= tune_freq;
      poll_cnt <= '0;
      stat_q   <= '0;
      go       <= 1'b0;
      done     <= 1'b0;
      error    <= 1'b0;
    end else begin
      go <= 1'b0;
      if (rd_valid && rd_idx == '0) stat_q <= rd_data;
      case (st)
        S_LAUNCH: begin
          go <= 1'b1;
          st <= S_WAIT;
        end
        S_WAIT: if (txn_done) begin
          if (txn_fail) begin
            error <= 1'b1;
            st    <= S_ERR;
          end else begin
            case (txn)
              TX_STAT: begin
                if (stat_q[READY_BIT]) begin
                  txn <= TX_REVCMD;
                  st  <= S_LAUNCH;
                end else begin
                  error <= 1'b1;
                  st    <= S_ERR;
                end
              end
              TX_POLLRD: begin
                if (stat_q[TUNED_BIT]) begin
                  txn <= TX_INTACK;
                  st  <= S_LAUNCH;
                end else if (poll_cnt == POLL_W'(MAX_POLLS - 1)) begin
                  error <= 1'b1;
                  st    <= S_ERR;
                end else begin
                  poll_cnt <= poll_cnt + POLL_W'(1);
                  txn      <= TX_POLLCMD;
                  st       <= S_LAUNCH;
                end
              end
              TX_PGRD: begin
                if (stat_q == PAGE_PAT) begin
                  done <= 1'b1;
                  st   <= S_DONE;
                end else begin
                  error <= 1'b1;
                  st    <= S_ERR;
                end
              end
              default: begin
                txn <= txn_e'(txn + 4'd1);
                st  <= S_LAUNCH;
              end
            endcase
          end
        end
        S_DONE, S_ERR: if (start) begin
          done     <= 1'b0;
          error    <= 1'b0;
          txn      <= TX_PWR;
          poll_cnt <= '0;
          freq_q   <= tune_freq;
          st       <= S_LAUNCH;
        end
        default: st <= S_ERR;
      endcase
    end
  end

  // R12: the two result flags are exclusive
  a_r12_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(done && error));

  // R12: results hold until a start pulse
  a_r12_done_hold: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);
  a_r12_error_hold: assert property (@(posedge clk) disable iff (rst)
    (error && !start) |=> error);

  // R12: bus quiet while a result is held
  a_r12_bus_quiet: assert property (@(posedge clk) disable iff (rst)
    (done || error) |-> !cmd_valid);

  // R11: a failed transaction ends the series with error
  a_r11_fail_to_error: assert property (@(posedge clk) disable iff (rst)
    (txn_done && txn_fail) |=> (error && !done));

  // R7: the poll counter never passes its bound
  a_r7_poll_bound: assert property (@(posedge clk) disable iff (rst)
    poll_cnt < POLL_W'(MAX_POLLS));

endmodule

// File: tb/test_radio_bringup_seq.sv
module test_radio_bringup_seq;

  localparam int MAXP = 4;
  localparam int NEVER = 1000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst, start;
  logic [15:0] tune_freq;
  logic        cmd_valid, cmd_nack, cmd_done, rsp_ack, done, error;
  logic [1:0]  cmd_op;
  logic [7:0]  cmd_wdata, rsp_rdata;
  logic [63:0] rev_data;

  radio_bringup_seq #(.MAX_POLLS(MAXP)) i_radio_bringup_seq (
    .clk(clk), .rst(rst), .start(start), .tune_freq(tune_freq),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_wdata(cmd_wdata), .cmd_nack(cmd_nack),
    .cmd_done(cmd_done), .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata),
    .done(done), .error(error), .rev_data(rev_data)
  );

  localparam int EV_START = 'h100;
  localparam int EV_STOP  = 'h200;
  localparam int EV_RACK  = 'h300;
  localparam int EV_RNACK = 'h301;

  int n_chk = 0, n_bad = 0;
  int log_q [0:1023];
  int exp_q [0:1023];
  int log_n, exp_n;

  // target model configuration and state
  int         cfg_stc, cfg_nack_at;
  logic [7:0] cfg_ready, cfg_corrupt, cfg_seed;
  int         wr_count, poll_seen, rd_k;
  logic [7:0] cur_addr, last_cmd, codec_ptr, codec_page;
  bit         want_addr, first_data;

  function automatic logic [7:0] rev_byte(int k);
    return 8'((k * 37 + 11) & 'hFF) ^ cfg_seed;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_model();
    log_n = 0; wr_count = 0; poll_seen = 0; rd_k = 0;
    cur_addr = 0; last_cmd = 0; codec_ptr = 0; codec_page = 0;
    want_addr = 0; first_data = 0;
  endtask

  task automatic serve();
    rsp_ack = 1'b0;
    rsp_rdata = 8'h00;
    case (cmd_op)
      2'd0: begin log_q[log_n] = EV_START; log_n++; want_addr = 1; rd_k = 0; end
      2'd3: begin log_q[log_n] = EV_STOP; log_n++; end
      2'd1: begin
        log_q[log_n] = int'(cmd_wdata); log_n++;
        if (want_addr) begin
          cur_addr = cmd_wdata; want_addr = 0; first_data = 1;
          rsp_ack = (cmd_wdata == 8'h22 || cmd_wdata == 8'h23 ||
                     cmd_wdata == 8'h30 || cmd_wdata == 8'h31) && (wr_count != cfg_nack_at);
        end else begin
          rsp_ack = (wr_count != cfg_nack_at);
          if (cur_addr == 8'h22 && first_data) last_cmd = cmd_wdata;
          if (cur_addr == 8'h30) begin
            if (first_data) codec_ptr = cmd_wdata;
            else if (codec_ptr == 8'h00) codec_page = cmd_wdata;
          end
          first_data = 0;
        end
        wr_count++;
      end
      default: begin
        log_q[log_n] = cmd_nack ? EV_RNACK : EV_RACK; log_n++;
        if (cur_addr == 8'h23) begin
          case (last_cmd)
            8'h01: rsp_rdata = cfg_ready;
            8'h10: rsp_rdata = rev_byte(rd_k);
            8'h14: begin
              if (rd_k == 0) rsp_rdata = (poll_seen >= cfg_stc) ? 8'h81 : 8'h80;
              else begin rsp_rdata = 8'h00; poll_seen++; end
            end
            default: rsp_rdata = 8'h00;
          endcase
        end else if (cur_addr == 8'h31) begin
          rsp_rdata = codec_page ^ cfg_corrupt;
        end
        rd_k++;
      end
    endcase
  endtask

  initial begin
    int lat;
    lat = 0;
    cmd_done = 1'b0; rsp_ack = 1'b0; rsp_rdata = 8'h00;
    forever begin
      @(negedge clk);
      if (cmd_done) cmd_done = 1'b0;
      else if (cmd_valid && !rst) begin
        if (lat == 1) begin serve(); cmd_done = 1'b1; lat = 0; end
        else lat++;
      end
    end
  end

  task automatic ep(input int v); exp_q[exp_n] = v; exp_n++; endtask
  task automatic ep_read(input int n);
    for (int i = 0; i < n; i++) ep(i == n - 1 ? EV_RNACK : EV_RACK);
  endtask

  // stage 0: up to status read; 1: up to last poll; 2: complete series
  task automatic build_exp(input logic [15:0] f, input int npolls, input int stage);
    exp_n = 0;
    ep(EV_START); ep('h22); ep('h01); ep('hC0); ep('h05); ep(EV_STOP);
    ep(EV_START); ep('h23); ep_read(1); ep(EV_STOP);
    if (stage == 0) return;
    ep(EV_START); ep('h22); ep('h10); ep(EV_STOP);
    ep(EV_START); ep('h23); ep_read(8); ep(EV_STOP);
    ep(EV_START); ep('h22); ep('h20); ep('h00); ep(int'(f[15:8])); ep(int'(f[7:0])); ep(EV_STOP);
    for (int p = 0; p < npolls; p++) begin
      ep(EV_START); ep('h22); ep('h14); ep(EV_STOP);
      ep(EV_START); ep('h23); ep_read(2); ep(EV_STOP);
    end
    if (stage == 1) return;
    ep(EV_START); ep('h22); ep('h22); ep('h01); ep(EV_STOP);
    ep(EV_START); ep('h30); ep('h00); ep('h42); ep(EV_STOP);
    ep(EV_START); ep('h30); ep('h00); ep(EV_STOP);
    ep(EV_START); ep('h31); ep_read(1); ep(EV_STOP);
  endtask

  task automatic cmp_stream(input string req, input string what);
    int bad;
    bad = -1;
    for (int i = 0; i < exp_n && i < log_n; i++)
      if (bad < 0 && log_q[i] != exp_q[i]) bad = i;
    if (bad >= 0) chk(0, req, {what, " stream entry"}, log_q[bad], exp_q[bad]);
    else chk(log_n == exp_n, req, {what, " stream length"}, log_n, exp_n);
  endtask

  task automatic chk_rev(input string req);
    int bad;
    bad = -1;
    for (int k = 0; k < 8; k++)
      if (bad < 0 && rev_data[8*k +: 8] !== rev_byte(k)) bad = k;
    if (bad >= 0) chk(0, req, "revision byte", int'(rev_data[8*bad +: 8]), int'(rev_byte(bad)));
    else chk(1, req, "revision bytes", 0, 0);
  endtask

  task automatic begin_run(input logic [15:0] f);
    clear_model();
    rst = 1'b1; start = 1'b0; tune_freq = f;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done || error) break;
    end
    repeat (20) @(negedge clk);
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] freqs [4];
    int nwr, pos, seen;
    freqs[0] = 16'h231E; freqs[1] = 16'h0000; freqs[2] = 16'hFFFF; freqs[3] = 16'h5A0F;
    cfg_stc = 0; cfg_nack_at = -1; cfg_ready = 8'h80; cfg_corrupt = 8'h00; cfg_seed = 8'h00;
    rst = 1'b1; start = 1'b0; tune_freq = 16'h231E;
    clear_model();
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(done == 0 && error == 0, "R12", "flags in reset", {done, error}, 0);
    chk(cmd_valid == 0, "R12", "bus idle in reset", cmd_valid, 0);
    chk(rev_data == 64'd0, "R3", "revision cleared in reset", int'(rev_data[31:0]), 0);

    // R1 R3 R5 R6 R8 R9 R10: sweep frequency and poll count
    for (int fi = 0; fi < 4; fi++) begin
      for (int s = 0; s < MAXP; s++) begin
        cfg_stc = s; cfg_seed = 8'(fi * 16 + s);
        begin_run(freqs[fi]);
        wait_end();
        chk(done && !error, "R6", "done after tune-complete", {done, error}, 2);
        build_exp(freqs[fi], s + 1, 2);
        cmp_stream("R1/R5/R6/R8/R9/R10", "full series");
        chk_rev("R3");
      end
    end

    // R7: tune never completes
    cfg_stc = NEVER; cfg_seed = 8'h5C;
    begin_run(16'h231E);
    wait_end();
    chk(error && !done, "R7", "poll bound error", {done, error}, 1);
    build_exp(16'h231E, MAXP, 1);
    cmp_stream("R7", "poll-bound series");

    // R4: ready flag clear, then R12 rerun by start
    cfg_stc = 0; cfg_ready = 8'h00;
    begin_run(16'h1234);
    wait_end();
    chk(error && !done, "R4", "not-ready error", {done, error}, 1);
    build_exp(16'h1234, 0, 0);
    cmp_stream("R4", "not-ready series");
    cfg_ready = 8'h80;
    clear_model();
    tune_freq = 16'h0ABC;
    pulse_start();
    chk(!error && !done, "R12", "flags cleared by start", {done, error}, 0);
    wait_end();
    chk(done && !error, "R12", "rerun from error", {done, error}, 2);
    build_exp(16'h0ABC, 1, 2);
    cmp_stream("R12", "rerun sampled new frequency");

    // R9: codec readback mismatch
    cfg_corrupt = 8'h01;
    begin_run(16'h2222);
    wait_end();
    chk(error && !done, "R9", "readback mismatch error", {done, error}, 1);
    build_exp(16'h2222, 1, 2);
    cmp_stream("R9", "mismatch series");
    cfg_corrupt = 8'h00;

    // R13: start and frequency change while running are ignored
    cfg_stc = 2;
    begin_run(16'h3141);
    repeat (60) @(negedge clk);
    tune_freq = 16'hBEEF;
    pulse_start();
    repeat (60) @(negedge clk);
    pulse_start();
    wait_end();
    chk(done && !error, "R13", "done despite mid-run start", {done, error}, 2);
    build_exp(16'h3141, 3, 2);
    cmp_stream("R13", "unchanged series");
    // R12: rerun from done with the new frequency
    clear_model();
    pulse_start();
    wait_end();
    chk(done && !error, "R12", "rerun from done", {done, error}, 2);
    build_exp(16'hBEEF, 3, 2);
    cmp_stream("R12", "rerun series");

    // R11: NACK injected on each written byte in turn
    cfg_stc = 0;
    build_exp(16'h231E, 1, 2);
    nwr = 0;
    for (int i = 0; i < exp_n; i++) if (exp_q[i] < 'h100) nwr++;
    for (int k = 0; k < nwr; k++) begin
      cfg_nack_at = k;
      begin_run(16'h231E);
      wait_end();
      build_exp(16'h231E, 1, 2);
      pos = -1; seen = 0;
      for (int i = 0; i < exp_n; i++) begin
        if (pos < 0 && exp_q[i] < 'h100) begin
          if (seen == k) pos = i;
          seen++;
        end
      end
      exp_n = pos + 1;
      ep(EV_STOP);
      chk(error && !done, "R11", "error after NACK", {done, error}, 1);
      cmp_stream("R11", "truncated series");
    end
    cfg_nack_at = -1;

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule